// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor's load/store port and a word-wide memory. It keeps recently used lines in two ways per set, so a request is looked up in both ways at once. Each line spans a power-of-two number of words. Writes stay in the cache until their line is replaced. A write that misses first brings the whole line in and then merges the new word into it.

The processor raises `cpuReq` with an address, a direction and write data, and holds them until it sees `cpuStall` low. On a hit the request completes on the cycle after it is accepted. On a miss the controller picks a victim way. If that victim holds modified data, it streams the victim's words out to memory, refills the line one word per memory handshake, and then completes the original request from the new line.

The memory side handles one word per beat. The cache holds `memReq`, `memWe`, `memAddr` and `memWdata` steady until the memory answers with a one-cycle `memAck`. On a read, `memRdata` is valid in that same cycle.

Top module: `assoc_wb_cache`

## Requirements
- R1: The word address splits, from most to least significant, into tag, set index and word offset. The set is the line number (address / LINE_WORDS) modulo NUM_SETS. Two lines with the same set but different tags can live side by side.
- R2: A read hit completes with `cpuStall` low on the first cycle after the request is accepted. It returns the stored word and makes no memory traffic.
- R3: A read miss whose victim is clean or invalid issues exactly LINE_WORDS read beats. The beats go to consecutive addresses starting at word offset 0 of the requested line, and then the request completes with the correct word.
- R4: The victim is the first way whose valid bit is clear, way 0 before way 1. Only when both ways are valid is the way named by the set's LRU bit replaced.
- R5: Each set's LRU bit is updated on every hit and every fill so that it names the other way. For the line sequence 0, 8, 0, 12, 8, which all fall in set 0 with the default geometry, the outcomes are miss, miss, hit, miss, miss, and line 12 hits afterwards.
- R6: A write hit updates only the cached word and marks the line modified. Memory is not written, and later reads return the new value.
- R7: Replacing a modified line first writes all LINE_WORDS of its words back to the victim's own line address, starting at offset 0. Every write beat comes before any refill read beat.
- R8: A write miss fetches the line and merges the written word into it. The other words of the line keep their memory values, and the merged line is written back when it is evicted.
- R9: Replacing an unmodified line issues no write beats.
- R10: During a memory beat, `memReq`, `memWe` and `memAddr` stay constant until `memAck`. Each beat moves one word.
- R11: After reset every line is invalid, `cpuStall` is low while no request is pending, and `memReq` is low.
- R12: `cpuStall` is high whenever a request is pending, except on the completing cycle, and there is no memory traffic on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpuReq | input | 1 | Processor request pending |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address |
| cpuWdata | input | DATA_W | Write data |
| cpuRdata | output | DATA_W | Read data, valid when the request completes |
| cpuStall | output | 1 | Request not yet complete |
| memReq | output | 1 | Memory beat requested |
| memWe | output | 1 | Beat is a write-back word |
| memAddr | output | ADDR_W | Word address of the beat |
| memWdata | output | DATA_W | Write-back word |
| memRdata | input | DATA_W | Refill word, valid with memAck |
| memAck | input | 1 | One-cycle beat completion |

## Verification
The checker watches the memory handshake on every cycle. Held beats must keep their address steady, and offsets must advance by one within a burst. No write beat may follow a read beat inside one miss, and no memory traffic may appear while the processor is released. What only the directed scenarios can show is the policy itself: which way gets replaced, that hit, miss and LRU outcomes match a reference sequence, that write hits leave memory untouched, and that merged or modified data reaches memory intact when its line is evicted.

// File: rtl/assoc_cache_pkg.sv
package assoc_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_COMPARE   = 2'd1,
    ST_WRITEBACK = 2'd2,
    ST_REFILL    = 2'd3
  } cacheState_t;

  // strobes from control into datapath
  typedef struct packed {
    logic latchReq;     // capture the processor request
    logic commit;       // complete a hit (write word, update LRU)
    logic latchVictim;  // freeze the chosen victim way
    logic selCnt;       // word select comes from beat counter
    logic cntClr;
    logic cntInc;
    logic memRd;        // refill beat active
    logic memWr;        // write-back beat active
    logic fillWord;     // store refill word
    logic fillDone;     // mark refilled line valid and clean
  } ctlStrobe_t;

  // status from datapath back to control
  typedef struct packed {
    logic hit;
    logic victimDirty;
    logic lastWord;
  } dpStatus_t;

endpackage

// File: rtl/cache_way_store.sv
module cache_way_store #(
  parameter int DATA_W     = 32,
  parameter int NUM_SETS   = 4,
  parameter int LINE_WORDS = 4,
  parameter int TAG_W      = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [$clog2(NUM_SETS)-1:0] setIdx,
  input  logic [$clog2(LINE_WORDS)-1:0] wordSel,
  input  logic                        wordWe,
  input  logic [DATA_W-1:0]           wordIn,
  input  logic                        markDirty,
  input  logic                        install,
  input  logic [TAG_W-1:0]            installTag,
  output logic                        lineValid,
  output logic                        lineDirty,
  output logic [TAG_W-1:0]            lineTag,
  output logic [DATA_W-1:0]           wordOut
);

  logic [NUM_SETS-1:0] validQ;
  logic [NUM_SETS-1:0] dirtyQ;
  logic [TAG_W-1:0]    tagQ  [NUM_SETS];
  logic [DATA_W-1:0]   dataQ [NUM_SETS][LINE_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= '0;
      dirtyQ <= '0;
    end else begin
      if (install) begin
        validQ[setIdx] <= 1'b1;
        dirtyQ[setIdx] <= 1'b0;
      end else if (markDirty) begin
        dirtyQ[setIdx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (install) tagQ[setIdx] <= installTag;
    if (wordWe)  dataQ[setIdx][wordSel] <= wordIn;
  end

  assign lineValid = validQ[setIdx];
  assign lineDirty = dirtyQ[setIdx];
  assign lineTag   = tagQ[setIdx];
  assign wordOut   = dataQ[setIdx][wordSel];

endmodule

// File: rtl/assoc_cache_dpath.sv
module assoc_cache_dpath
  import assoc_cache_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int NUM_SETS   = 4,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        strobe,
  output dpStatus_t         status,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);

  localparam int WAYS  = 2;
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W = $clog2(NUM_SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic [ADDR_W-1:0] reqAddrQ;
  logic              reqWeQ;
  logic [DATA_W-1:0] reqDataQ;
  logic              victimQ;
  logic [OFF_W-1:0]  cntQ;
  logic [NUM_SETS-1:0] lruQ;

  logic [OFF_W-1:0] reqOff;
  logic [IDX_W-1:0] reqSet;
  logic [TAG_W-1:0] reqTag;

  assign reqOff = reqAddrQ[OFF_W-1:0];
  assign reqSet = reqAddrQ[OFF_W +: IDX_W];
  assign reqTag = reqAddrQ[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0] wayValid, wayDirty, hitVec, wayWe, wayMark, wayInstall;
  logic [TAG_W-1:0]  wayTag  [WAYS];
  logic [DATA_W-1:0] wayWord [WAYS];
  logic [OFF_W-1:0]  wordSel;
  logic [DATA_W-1:0] wordIn;
  logic              hitWay;
  logic              pick;
  logic              writeHit;

  assign wordSel  = strobe.selCnt ? cntQ : reqOff;
  assign wordIn   = strobe.fillWord ? memRdata : reqDataQ;
  assign writeHit = strobe.commit && reqWeQ;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hitVec[w]     = wayValid[w] && (wayTag[w] == reqTag);
    assign wayMark[w]    = writeHit && hitVec[w];
    assign wayWe[w]      = wayMark[w] || (strobe.fillWord && (victimQ == 1'(w)));
    assign wayInstall[w] = strobe.fillDone && (victimQ == 1'(w));

    cache_way_store #(
      .DATA_W(DATA_W), .NUM_SETS(NUM_SETS),
      .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W)
    ) u_store (
      .clk(clk), .rst(rst),
      .setIdx(reqSet), .wordSel(wordSel),
      .wordWe(wayWe[w]), .wordIn(wordIn),
      .markDirty(wayMark[w]),
      .install(wayInstall[w]), .installTag(reqTag),
      .lineValid(wayValid[w]), .lineDirty(wayDirty[w]),
      .lineTag(wayTag[w]), .wordOut(wayWord[w])
    );
  end

  assign hitWay = hitVec[1];

  // invalid way first (way 0 before way 1), then LRU
  always_comb begin
    if (!wayValid[0])      pick = 1'b0;
    else if (!wayValid[1]) pick = 1'b1;
    else                   pick = lruQ[reqSet];
  end

  assign status.hit         = |hitVec;
  assign status.victimDirty = wayValid[pick] && wayDirty[pick];
  assign status.lastWord    = (cntQ == OFF_W'(LINE_WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      reqAddrQ <= '0;
      reqWeQ   <= 1'b0;
      reqDataQ <= '0;
      victimQ  <= 1'b0;
      cntQ     <= '0;
      lruQ     <= '0;
    end else begin
      if (strobe.latchReq) begin
        reqAddrQ <= cpuAddr;
        reqWeQ   <= cpuWe;
        reqDataQ <= cpuWdata;
      end
      if (strobe.latchVictim) victimQ <= pick;
      if (strobe.cntClr)      cntQ <= '0;
      else if (strobe.cntInc) cntQ <= cntQ + 1'b1;
      if (strobe.commit)        lruQ[reqSet] <= ~hitWay;
      else if (strobe.fillDone) lruQ[reqSet] <= ~victimQ;
    end
  end

  assign memReq   = strobe.memRd || strobe.memWr;
  assign memWe    = strobe.memWr;
  assign memAddr  = {(strobe.memWr ? wayTag[victimQ] : reqTag), reqSet, cntQ};
  assign memWdata = wayWord[victimQ];
  assign cpuRdata = wayWord[hitWay];

endmodule

// File: rtl/assoc_cache_ctrl.sv
module assoc_cache_ctrl
  import assoc_cache_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cpuReq,
  input  logic       memAck,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       cpuStall
);

  cacheState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  always_comb begin
    strobe   = '0;
    stateD   = stateQ;
    cpuStall = 1'b1;
    case (stateQ)
      ST_IDLE: begin
        cpuStall = cpuReq;
        if (cpuReq) begin
          strobe.latchReq = 1'b1;
          stateD = ST_COMPARE;
        end
      end
      ST_COMPARE: begin
        if (status.hit) begin
          cpuStall      = 1'b0;
          strobe.commit = 1'b1;
          stateD        = ST_IDLE;
        end else begin
          strobe.latchVictim = 1'b1;
          strobe.cntClr      = 1'b1;
          stateD = status.victimDirty ? ST_WRITEBACK : ST_REFILL;
        end
      end
      ST_WRITEBACK: begin
        strobe.selCnt = 1'b1;
        strobe.memWr  = 1'b1;
        if (memAck) begin
          if (status.lastWord) begin
            strobe.cntClr = 1'b1;
            stateD = ST_REFILL;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
      end
      ST_REFILL: begin
        strobe.selCnt = 1'b1;
        strobe.memRd  = 1'b1;
        if (memAck) begin
          strobe.fillWord = 1'b1;
          if (status.lastWord) begin
            strobe.fillDone = 1'b1;
            strobe.cntClr   = 1'b1;
            stateD = ST_COMPARE;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/assoc_wb_cache.sv
module assoc_wb_cache
  import assoc_cache_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int NUM_SETS   = 4,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuStall,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck
);

  ctlStrobe_t strobe;
  dpStatus_t  status;

  assoc_cache_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .memAck(memAck),
    .status(status), .strobe(strobe), .cpuStall(cpuStall)
  );

  assoc_cache_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .NUM_SETS(NUM_SETS), .LINE_WORDS(LINE_WORDS)
  ) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .status(status),
    .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

endmodule

// File: rtl/assoc_cache_chk.sv
module assoc_cache_chk #(
  parameter int ADDR_W     = 10,
  parameter int LINE_WORDS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cpuStall,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr
);

  localparam int OFF_W = $clog2(LINE_WORDS);

  // R10
  beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  // R7
  wb_before_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memWe) |=> !(memReq && memWe));

  // R12
  quiet_release_chk: assert property (@(posedge clk) disable iff (rst)
    !cpuStall |-> !memReq);

  // R3
  burst_step_chk: assert property (@(posedge clk) disable iff (rst)
    (memReq && memAck) |=> (!memReq || (memWe != $past(memWe)) ||
      (memAddr[OFF_W-1:0] == OFF_W'($past(memAddr[OFF_W-1:0]) + 1))));

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !memReq);

endmodule

bind assoc_wb_cache assoc_cache_chk #(
  .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)
) u_chk (
  .clk(clk), .rst(rst), .cpuStall(cpuStall), .memReq(memReq),
  .memWe(memWe), .memAck(memAck), .memAddr(memAddr)
);

// File: tb/sim_assoc_wb_cache.sv
module sim_assoc_wb_cache;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT    = 3;
  localparam int MEM_WORDS  = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpuReq = 1'b0, cpuWe = 1'b0;
  logic [9:0]  cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic [31:0] cpuRdata;
  logic        cpuStall;
  logic        memReq, memWe;
  logic [9:0]  memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assoc_wb_cache u0 (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuStall(cpuStall),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck)
  );

  // memory model with beat log
  logic [31:0] mem [MEM_WORDS];
  logic [31:0] shadow [MEM_WORDS];
  logic        memInitDone = 1'b0;
  int          latCnt = 0;
  int          beatCount = 0;
  logic [9:0]  logAddr [256];
  logic        logWe [256];

  always @(posedge clk) begin
    if (!memInitDone) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= 32'hC0DE0000 ^ (i * 32'h00010101);
      memInitDone <= 1'b1;
    end
    if (rst || memAck) begin
      memAck <= 1'b0;
      latCnt <= 0;
    end else if (memReq) begin
      if (latCnt == MEM_LAT - 1) begin
        memAck <= 1'b1;
        latCnt <= 0;
        if (memWe) mem[memAddr] <= memWdata;
        else       memRdata <= mem[memAddr];
        logAddr[beatCount % 256] <= memAddr;
        logWe[beatCount % 256]   <= memWe;
        beatCount <= beatCount + 1;
      end else begin
        latCnt <= latCnt + 1;
      end
    end else begin
      latCnt <= 0;
    end
  end

  int nChecks = 0;
  int nFail = 0;
  bit summaryDone = 0;

  logic [31:0] lastRd;
  int lastCyc, lastNRd, lastNWr, lastFirstWr, lastFirstRd;
  bit lastOrdered;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    cpuReq = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < MEM_WORDS; i++) shadow[i] = mem[i];
    @(negedge clk);
  endtask

  task automatic access(input logic we, input int addr, input logic [31:0] wd);
    int start;
    bit seenRd;
    start = beatCount;
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr[9:0]; cpuWdata = wd;
    lastCyc = 0;
    forever begin
      @(negedge clk);
      lastCyc++;
      if (!cpuStall) break;
      if (lastCyc > 2000) begin
        chk(1'b0, "watchdog", 32'(lastCyc), 32'd2000);
        break;
      end
    end
    lastRd = cpuRdata;
    cpuReq = 1'b0;
    if (we) shadow[addr] = wd;
    @(negedge clk);
    lastNRd = 0; lastNWr = 0; lastFirstWr = -1; lastFirstRd = -1;
    lastOrdered = 1; seenRd = 0;
    for (int i = start; i < beatCount; i++) begin
      if (logWe[i % 256]) begin
        if (lastFirstWr < 0) lastFirstWr = int'(logAddr[i % 256]);
        lastNWr++;
        if (seenRd) lastOrdered = 0;
      end else begin
        if (lastFirstRd < 0) lastFirstRd = int'(logAddr[i % 256]);
        lastNRd++;
        seenRd = 1;
      end
    end
  endtask

  task automatic testReset();
    doReset();
    chk(cpuStall == 1'b0, "R11 stall idle", 32'(cpuStall), 32'd0);
    chk(memReq == 1'b0, "R11 memReq idle", 32'(memReq), 32'd0);
  endtask

  task automatic testReadMissHit();
    access(1'b0, 'h15, '0);
    chk(lastNRd == 4 && lastNWr == 0, "R3 miss beats", 32'(lastNRd*16 + lastNWr), 32'h40);
    chk(lastFirstRd == 'h14, "R3 refill start", 32'(lastFirstRd), 32'h14);
    chk(lastCyc > 1, "R12 stalled on miss", 32'(lastCyc), 32'd2);
    chk(lastRd == shadow['h15], "R3 miss data", lastRd, shadow['h15]);
    chk(cpuStall == 1'b0, "R12 released after done", 32'(cpuStall), 32'd0);
    for (int a = 'h14; a < 'h18; a++) begin
      access(1'b0, a, '0);
      chk(lastCyc == 1 && lastNRd == 0, "R2 hit timing", 32'(lastCyc), 32'd1);
      chk(lastRd == shadow[a], "R10 refilled word", lastRd, shadow[a]);
    end
  endtask

  task automatic testWriteHit();
    logic [31:0] orig;
    orig = mem['h16];
    access(1'b1, 'h16, 32'hDEAD0016);
    chk(lastCyc == 1 && lastNWr == 0 && lastNRd == 0, "R6 write hit quiet", 32'(lastNWr), 32'd0);
    chk(mem['h16] == orig, "R6 memory untouched", mem['h16], orig);
    access(1'b0, 'h16, '0);
    chk(lastRd == 32'hDEAD0016, "R6 readback", lastRd, 32'hDEAD0016);
  endtask

  task automatic testEvict();
    access(1'b0, 'h24, '0);
    chk(lastNRd == 4 && lastNWr == 0, "R4 fill invalid way", 32'(lastNWr), 32'd0);
    access(1'b0, 'h15, '0);
    chk(lastCyc == 1 && lastNRd == 0, "R4 first line kept", 32'(lastNRd), 32'd0);
    access(1'b0, 'h34, '0);
    chk(lastNWr == 0 && lastNRd == 4, "R9 clean victim", 32'(lastNWr), 32'd0);
    access(1'b0, 'h44, '0);
    chk(lastNWr == 4 && lastNRd == 4, "R7 dirty victim beats", 32'(lastNWr*16 + lastNRd), 32'h44);
    chk(lastFirstWr == 'h14, "R7 writeback address", 32'(lastFirstWr), 32'h14);
    chk(lastOrdered, "R7 writes before reads", 32'(lastOrdered), 32'd1);
    chk(mem['h16] == 32'hDEAD0016, "R7 written data", mem['h16], 32'hDEAD0016);
    chk(lastRd == shadow['h44], "R7 new line data", lastRd, shadow['h44]);
  endtask

  task automatic testWriteMiss();
    doReset();
    access(1'b1, 'h52, 32'hBEEF0052);
    chk(lastNRd == 4 && lastNWr == 0, "R8 allocate on write", 32'(lastNRd), 32'd4);
    access(1'b0, 'h53, '0);
    chk(lastCyc == 1 && lastRd == shadow['h53], "R8 neighbour word", lastRd, shadow['h53]);
    access(1'b0, 'h52, '0);
    chk(lastRd == 32'hBEEF0052, "R8 merged word", lastRd, 32'hBEEF0052);
    access(1'b0, 'h60, '0);
    access(1'b0, 'h70, '0);
    chk(lastNWr == 4 && lastFirstWr == 'h50, "R8 merged line written back", 32'(lastFirstWr), 32'h50);
    chk(mem['h52] == 32'hBEEF0052, "R8 memory merged", mem['h52], 32'hBEEF0052);
    chk(mem['h53] == shadow['h53], "R8 memory neighbour", mem['h53], shadow['h53]);
  endtask

  task automatic testLruSequence();
    int seq [6] = '{'h00, 'h20, 'h00, 'h30, 'h20, 'h30};
    bit expMiss [6] = '{1, 1, 0, 1, 1, 0};
    doReset();
    for (int k = 0; k < 6; k++) begin
      access(1'b0, seq[k], '0);
      chk((lastNRd > 0) == expMiss[k], "R5 hit/miss pattern", 32'(lastNRd > 0), 32'(expMiss[k]));
      chk(lastRd == shadow[seq[k]], "R5 data", lastRd, shadow[seq[k]]);
    end
  endtask

  task automatic testSetMapping();
    doReset();
    access(1'b0, 'h15, '0);
    access(1'b0, 'h55, '0);
    chk(lastNRd == 4 && lastFirstRd == 'h54, "R1 same set other tag", 32'(lastFirstRd), 32'h54);
    access(1'b0, 'h19, '0);
    chk(lastFirstRd == 'h18, "R1 other set", 32'(lastFirstRd), 32'h18);
    access(1'b0, 'h15, '0);
    chk(lastNRd == 0 && lastRd == shadow['h15], "R1 coexisting lines", 32'(lastNRd), 32'd0);
    access(1'b0, 'h56, '0);
    chk(lastNRd == 0 && lastRd == shadow['h56], "R1 second way hit", lastRd, shadow['h56]);
  endtask

  initial begin
    testReset();
    testReadMissHit();
    testWriteHit();
    testEvict();
    testWriteMiss();
    testLruSequence();
    testSetMapping();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    end
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!summaryDone) begin
      summaryDone = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    end
    $finish;
  end

endmodule